// File: doc/BRIEF.md
# Endpoint stall flag register

This block holds the stall state of the four endpoints of a USB function and tells the protocol engine which endpoints must answer the host with a STALL handshake. Software reads and writes one 8-bit register. The low four bits are one stall flag per endpoint. The next bit is a single auto-clear enable that applies to all endpoints. The top three bits are reserved.

Hardware can clear the flags on its own in two ways. The endpoint 0 flag drops when the function decodes a standard command by itself. With auto-clear enabled, a flag also drops once the protocol engine reports that a STALL handshake has gone out on that endpoint. While a setup packet is pending, software cannot set the endpoint 0 flag, so a stale stall cannot block the new control transfer.

Top module: `ep_stall_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00 and every `stall` output is 0.
- R2: `rd_data` bits 3..0 are the stall flags of endpoints 3..0, bit 4 is the auto-clear enable, and bits 7..5 always read 0; writing the bits 7..5 has no effect.
- R3: A cycle with `wr_en` high loads `wr_data[3:0]` into the stall flags and `wr_data[4]` into the auto-clear enable, visible from the next cycle, except where R4, R5 or R6 say otherwise for endpoint 0.
- R4: When `ep0_cmd_done` is high, the endpoint 0 flag is 0 in the next cycle, even if the same cycle writes 1 to it.
- R5: While `setup_pending` is high, a write of 1 to bit 0 leaves the endpoint 0 flag unchanged; a write of 0 still clears it.
- R6: When the auto-clear enable is 1 and `hs_sent[n]` is high, flag n is 0 in the next cycle. For endpoint 0 this wins over a same-cycle write. The other flags are unchanged. When the enable is 0, `hs_sent` has no effect.
- R7: For endpoints 1..3, a write in the same cycle as an auto-clear event sets the flag to the written value.
- R8: `stall[n]` always equals `rd_data[n]` for n in 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_data | input | 8 | CPU write data |
| setup_pending | input | 1 | Setup packet received and not yet handled |
| ep0_cmd_done | input | 1 | Locally decoded command received on endpoint 0 |
| hs_sent | input | 4 | STALL handshake returned, one bit per endpoint |
| rd_data | output | 8 | Register read value |
| stall | output | 4 | Per-endpoint stall state |

## Verification
A CPU write can land in the same cycle as a hardware clear: a decoded command or an auto-clear on endpoint 0, and an auto-clear on endpoints 1..3. The bench preloads every one of the 32 register states. From each state it applies one vector, crossing the write strobe and several data patterns with every combination of `setup_pending`, `ep0_cmd_done` and the four `hs_sent` bits, so that each collision is hit. Each result is compared one cycle later against a value computed from the priority rules: the hardware clear wins on endpoint 0, and the write wins on the other endpoints.

// File: rtl/ep_stall_ctrl.sv
module ep_stall_ctrl #(
  parameter int NUM_EP = 4,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              setup_pending,
  input  logic              ep0_cmd_done,
  input  logic [NUM_EP-1:0] hs_sent,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_EP-1:0] stall
);
  localparam int ACE_BIT = NUM_EP;
  localparam int RSV_W   = REG_W - NUM_EP - 1;

  logic [NUM_EP-1:0] stall_q;
  logic              ace_q;
  logic              ep0_hw_clr;

  assign ep0_hw_clr = ep0_cmd_done | (ace_q & hs_sent[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ace_q <= 1'b0;
    else if (wr_en) ace_q <= wr_data[ACE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q[0] <= 1'b0;
    else if (ep0_hw_clr) stall_q[0] <= 1'b0;
    else if (wr_en && !(wr_data[0] && setup_pending)) stall_q[0] <= wr_data[0];
  end

  for (genvar n = 1; n < NUM_EP; n++) begin : g_ep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stall_q[n] <= 1'b0;
      else if (wr_en) stall_q[n] <= wr_data[n];
      else if (ace_q && hs_sent[n]) stall_q[n] <= 1'b0;
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> stall[n] == $past(wr_data[n])); // R7
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !hs_sent[n]) |=> $stable(stall[n])); // R6
  end

  assign stall   = stall_q;
  assign rd_data = {{RSV_W{1'b0}}, ace_q, stall_q};

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ep0_cmd_done |=> !stall[0]); // R4
  AST_SETUP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && setup_pending && !stall[0]) |=> !stall[0]); // R5
  AST_AUTOCLR_EP0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[ACE_BIT] && hs_sent[0]) |=> !stall[0]); // R6
  AST_ACE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[ACE_BIT] == $past(wr_data[ACE_BIT])); // R3
endmodule

// File: tb/ep_stall_ctrl_bench.sv
module ep_stall_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       setup_pending = 1'b0;
  logic       ep0_cmd_done = 1'b0;
  logic [3:0] hs_sent = '0;
  logic [7:0] rd_data;
  logic [3:0] stall;
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ep_stall_ctrl u_ep_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .setup_pending(setup_pending), .ep0_cmd_done(ep0_cmd_done),
    .hs_sent(hs_sent), .rd_data(rd_data), .stall(stall)
  );

  function automatic logic [7:0] model(input logic [4:0] s, input logic w,
      input logic [7:0] d, input logic su, input logic cmd, input logic [3:0] hs);
    logic [7:0] r;
    r = '0;
    if (cmd || (s[4] && hs[0])) r[0] = 1'b0;
    else if (w) r[0] = (d[0] && su) ? s[0] : d[0];
    else r[0] = s[0];
    for (int n = 1; n < 4; n++)
      r[n] = w ? d[n] : ((s[4] && hs[n]) ? 1'b0 : s[n]);
    r[4] = w ? d[4] : s[4];
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [7:0] d, input logic su,
      input logic cmd, input logic [3:0] hs);
    @(negedge clk);
    wr_en = w; wr_data = d; setup_pending = su; ep0_cmd_done = cmd; hs_sent = hs;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    string tag;
    logic [7:0] d, exp;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00);
    check("R1", {4'h0, stall}, 8'h00);
    rst_n = 1'b1;
    // R2: reserved bits ignored on write, read as zero
    drive(1'b1, 8'hFF, 1'b0, 1'b0, 4'h0);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
    check("R2", rd_data, 8'h1F);
    // R5: write of 0 still clears while setup pending
    drive(1'b1, 8'h00, 1'b1, 1'b0, 4'h0);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
    check("R5", rd_data, 8'h00);
    for (int s = 0; s < 32; s++) begin
      for (int v = 0; v < 1024; v++) begin
        logic w, su, cmd;
        logic [3:0] hs;
        w = v[0]; su = v[1]; cmd = v[2]; hs = v[6:3];
        d = 8'((v[9:7] * 73) + (s * 5) + v[0]);
        drive(1'b1, 8'(s), 1'b0, 1'b0, 4'h0);
        drive(w, d, su, cmd, hs);
        exp = model(5'(s), w, d, su, cmd, hs);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
        if (cmd) tag = "R4";
        else if (w && su && d[0]) tag = "R5";
        else if (s[4] && hs != 0) tag = w ? "R7" : "R6";
        else tag = "R3";
        check(tag, rd_data, exp);
        if (stall !== rd_data[3:0]) check("R8", {4'h0, stall}, {4'h0, rd_data[3:0]});
      end
    end
    finish_run();
  end
endmodule